// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block is the host-facing register file of a 16550-style serial port. A host reaches it through a 3-bit address, separate read and write strobes, and 8-bit data. The value last written to the line control register chooses which set of registers appears at the eight addresses:

- **Normal bank:** the usual interrupt-enable, FIFO-control, line-control and modem-control registers.
- **Divisor bank:** the two baud divisor bytes, plus a fixed revision and device-ID pair that shows only while the divisor is zero.
- **Enhanced bank:** the enhanced feature register, the IR pulse-width register, the extra-feature register, and two XON and two XOFF flow-control characters.

The block stores these values and exports them to the serial datapath. It also exports the decoded enable bits of the enhanced feature register. The enhanced-enable bit acts as a write lock. While it is clear, the upper control bits of several normal-bank registers keep their values, and so do the two enhanced-bank configuration registers. Shifting, FIFOs, the baud generator and interrupt status logic are outside this block.

Top module: `uart_bank_regs`

## Requirements
- R1: A synchronous active-high reset clears every stored register to 0x00, so the normal bank is selected and all enhanced enables are 0.
- R2: With line control bit 7 at 0 (normal bank):
  - address 001 is the interrupt-enable register (read/write);
  - address 010 writes the FIFO-control register and reads 0x01 (no interrupt pending);
  - address 100 is the modem-control register (read/write);
  - addresses 000, 101, 110 and 111 read 0x00, and writes there change no stored register.
- R3: With line control bit 7 at 1 and line control not equal to 0xBF (divisor bank), address 000 reads and writes the divisor low byte and address 001 the divisor high byte. Writing these addresses leaves the interrupt-enable register unchanged.
- R4: In the divisor bank, while both divisor bytes are 0x00, a read at 000 returns the revision byte (parameter, default 0x01) and a read at 001 returns the device ID 0x04. Once the divisor is nonzero, these reads return the stored bytes.
- R5: With line control exactly 0xBF (enhanced bank), the registers are mapped as follows, all read/write:
  - 010: enhanced feature register;
  - 100: XON1; 101: XON2; 110: XOFF1; 111: XOFF2;
  - 000: IR pulse-width register; 001: extra-feature register.
  Writes in this bank do not alter the divisor.
- R6: The enhanced feature register drives its outputs by bit position:
  - bit 7: auto CTS enable;
  - bit 6: auto RTS enable;
  - bit 5: special-character enable;
  - bit 4: enhanced enable;
  - bits 3:0: software flow-control mode.
- R7: While enhanced enable is 0, writes keep the old values of interrupt-enable bits 7:4, FIFO-control bits 5:4, modem-control bits 7:5, and all of the IR pulse-width and extra-feature registers. The remaining bits of a write still update.
- R8: While enhanced enable is 1, writes to those registers update all eight bits.
- R9: Address 011 reads and writes the line control register in every bank.
- R10: A write takes effect on the stored value one clock after the strobe. Read data is combinational from the current address and state, and it is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when rd_en is low |
| lcr_q | output | 8 | Line control register |
| ier_q | output | 8 | Interrupt-enable register |
| fcr_q | output | 8 | FIFO-control register |
| mcr_q | output | 8 | Modem-control register |
| divisor_q | output | 16 | Baud divisor {high, low} |
| irpw_q | output | 8 | IR pulse-width register |
| xfr_q | output | 8 | Extra-feature register |
| xon1_q | output | 8 | XON character 1 |
| xon2_q | output | 8 | XON character 2 |
| xoff1_q | output | 8 | XOFF character 1 |
| xoff2_q | output | 8 | XOFF character 2 |
| auto_cts_en | output | 1 | Auto CTS enable |
| auto_rts_en | output | 1 | Auto RTS enable |
| spec_char_en | output | 1 | Special-character enable |
| enh_en | output | 1 | Enhanced functions enable / write unlock |
| swfc_mode | output | 4 | Software flow-control mode |

## Verification
Stored outputs change on the first rising edge after a write strobe. The bench therefore drives every write on a falling edge, releases it on the next falling edge, and only then compares the exported registers.

Read data depends only on the current address and state. It is checked one nanosecond after the address and read strobe are applied, inside the same low clock phase.

A read issued together with a write in the same phase must still show the old value, and this is checked before the edge. Because the bank changes one cycle after a line control write, every bank switch is completed as its own write before any access to the new bank.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [REG_W-1:0] ENH_KEY   = 8'hBF;
    localparam logic [REG_W-1:0] ISR_IDLE  = 8'h01;
    localparam logic [REG_W-1:0] IER_LOCK  = 8'hF0;
    localparam logic [REG_W-1:0] FCR_LOCK  = 8'h30;
    localparam logic [REG_W-1:0] MCR_LOCK  = 8'hE0;
    localparam logic [REG_W-1:0] FULL_LOCK = 8'hFF;

    localparam int EFR_ENH_BIT = 4;

    typedef enum logic [1:0] {
        BANK_NORM = 2'd0,
        BANK_DIV  = 2'd1,
        BANK_ENH  = 2'd2
    } bank_e;

    typedef struct packed {
        logic [REG_W-1:0] lcr;
        logic [REG_W-1:0] ier;
        logic [REG_W-1:0] fcr;
        logic [REG_W-1:0] mcr;
        logic [REG_W-1:0] dll;
        logic [REG_W-1:0] dlm;
        logic [REG_W-1:0] efr;
        logic [REG_W-1:0] irpw;
        logic [REG_W-1:0] xfr;
        logic [REG_W-1:0] xon1;
        logic [REG_W-1:0] xon2;
        logic [REG_W-1:0] xoff1;
        logic [REG_W-1:0] xoff2;
    } regs_t;

    function automatic bank_e pick_bank(input logic [REG_W-1:0] lcr);
        if (lcr == ENH_KEY)  return BANK_ENH;
        else if (lcr[REG_W-1]) return BANK_DIV;
        else                 return BANK_NORM;
    endfunction

    // Bits under mask keep their old value when locked.
    function automatic logic [REG_W-1:0] lock_merge(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [REG_W-1:0] mask,
        input logic             locked
    );
        if (locked) return (old_v & mask) | (new_v & ~mask);
        else        return new_v;
    endfunction
endpackage

// File: rtl/uart_bank_sel.sv
module uart_bank_sel
    import uart_bank_pkg::*;
(
    input  logic [REG_W-1:0] lcr,
    output bank_e            bank
);
    always_comb bank = pick_bank(lcr);
endmodule

// File: rtl/uart_bank_store.sv
module uart_bank_store
    import uart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_e             bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output regs_t             regs
);
    regs_t nxt;
    logic  locked;

    always_comb begin
        locked = !regs.efr[EFR_ENH_BIT];
        nxt    = regs;
        if (wr_en) begin
            unique case (addr)
                3'd0: begin
                    if (bank == BANK_DIV)      nxt.dll  = wdata;
                    else if (bank == BANK_ENH) nxt.irpw = lock_merge(regs.irpw, wdata, FULL_LOCK, locked);
                end
                3'd1: begin
                    if (bank == BANK_DIV)      nxt.dlm = wdata;
                    else if (bank == BANK_ENH) nxt.xfr = lock_merge(regs.xfr, wdata, FULL_LOCK, locked);
                    else                       nxt.ier = lock_merge(regs.ier, wdata, IER_LOCK, locked);
                end
                3'd2: begin
                    if (bank == BANK_ENH) nxt.efr = wdata;
                    else                  nxt.fcr = lock_merge(regs.fcr, wdata, FCR_LOCK, locked);
                end
                3'd3: nxt.lcr = wdata;
                3'd4: begin
                    if (bank == BANK_ENH) nxt.xon1 = wdata;
                    else                  nxt.mcr  = lock_merge(regs.mcr, wdata, MCR_LOCK, locked);
                end
                3'd5: if (bank == BANK_ENH) nxt.xon2  = wdata;
                3'd6: if (bank == BANK_ENH) nxt.xoff1 = wdata;
                3'd7: if (bank == BANK_ENH) nxt.xoff2 = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= '0;
        else     regs <= nxt;
    end
endmodule

// File: rtl/uart_bank_rdmux.sv
module uart_bank_rdmux
    import uart_bank_pkg::*;
#(
    parameter logic [REG_W-1:0] REV_ID = 8'h01,
    parameter logic [REG_W-1:0] DEV_ID = 8'h04
) (
    input  bank_e             bank,
    input  regs_t             regs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata
);
    logic             div_zero;
    logic [REG_W-1:0] sel;

    always_comb begin
        div_zero = (regs.dll == '0) && (regs.dlm == '0);
        sel      = '0;
        unique case (addr)
            3'd0: begin
                if (bank == BANK_DIV)      sel = div_zero ? REV_ID : regs.dll;
                else if (bank == BANK_ENH) sel = regs.irpw;
            end
            3'd1: begin
                if (bank == BANK_DIV)      sel = div_zero ? DEV_ID : regs.dlm;
                else if (bank == BANK_ENH) sel = regs.xfr;
                else                       sel = regs.ier;
            end
            3'd2: sel = (bank == BANK_ENH) ? regs.efr : ISR_IDLE;
            3'd3: sel = regs.lcr;
            3'd4: sel = (bank == BANK_ENH) ? regs.xon1 : regs.mcr;
            3'd5: if (bank == BANK_ENH) sel = regs.xon2;
            3'd6: if (bank == BANK_ENH) sel = regs.xoff1;
            3'd7: if (bank == BANK_ENH) sel = regs.xoff2;
            default: ;
        endcase
        rdata = rd_en ? sel : '0;
    end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_bank_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h01,
    parameter logic [7:0] DEV_ID = 8'h04
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  lcr_q,
    output logic [7:0]  ier_q,
    output logic [7:0]  fcr_q,
    output logic [7:0]  mcr_q,
    output logic [15:0] divisor_q,
    output logic [7:0]  irpw_q,
    output logic [7:0]  xfr_q,
    output logic [7:0]  xon1_q,
    output logic [7:0]  xon2_q,
    output logic [7:0]  xoff1_q,
    output logic [7:0]  xoff2_q,
    output logic        auto_cts_en,
    output logic        auto_rts_en,
    output logic        spec_char_en,
    output logic        enh_en,
    output logic [3:0]  swfc_mode
);
    bank_e bank;
    regs_t regs;

    uart_bank_sel u_sel (
        .lcr  (regs.lcr),
        .bank (bank)
    );

    uart_bank_store u_store (
        .clk   (clk),
        .rst   (rst),
        .bank  (bank),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .regs  (regs)
    );

    uart_bank_rdmux #(.REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_rd (
        .bank  (bank),
        .regs  (regs),
        .addr  (addr),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    assign lcr_q        = regs.lcr;
    assign ier_q        = regs.ier;
    assign fcr_q        = regs.fcr;
    assign mcr_q        = regs.mcr;
    assign divisor_q    = {regs.dlm, regs.dll};
    assign irpw_q       = regs.irpw;
    assign xfr_q        = regs.xfr;
    assign xon1_q       = regs.xon1;
    assign xon2_q       = regs.xon2;
    assign xoff1_q      = regs.xoff1;
    assign xoff2_q      = regs.xoff2;
    assign auto_cts_en  = regs.efr[7];
    assign auto_rts_en  = regs.efr[6];
    assign spec_char_en = regs.efr[5];
    assign enh_en       = regs.efr[4];
    assign swfc_mode    = regs.efr[3:0];
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
    parameter logic [7:0] REV_ID = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic [7:0]  lcr_q,
    input logic [7:0]  ier_q,
    input logic [15:0] divisor_q,
    input logic        enh_en,
    input logic [7:0]  efr_view
);
    logic div_bank;
    logic enh_bank;
    assign div_bank = lcr_q[7] && (lcr_q != 8'hBF);
    assign enh_bank = (lcr_q == 8'hBF);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (lcr_q == 8'h00 && ier_q == 8'h00 && divisor_q == 16'h0 && efr_view == 8'h00));

    p_div_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr[2:1] == 2'b00 && div_bank) |=> $stable(divisor_q));

    p_rev_id_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd0 && div_bank && divisor_q == 16'h0) |-> rdata == REV_ID);

    p_efr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 3'd2 && enh_bank) |=> $stable(efr_view));

    p_ier_lock_r7: assert property (@(posedge clk) disable iff (rst)
        !enh_en |=> ier_q[7:4] == $past(ier_q[7:4]));

    p_lcr_any_bank_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd3) |=> lcr_q == $past(wdata));

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 8'h00);
endmodule

bind uart_bank_regs uart_bank_regs_chk #(.REV_ID(REV_ID)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .lcr_q     (lcr_q),
    .ier_q     (ier_q),
    .divisor_q (divisor_q),
    .enh_en    (enh_en),
    .efr_view  ({auto_cts_en, auto_rts_en, spec_char_en, enh_en, swfc_mode})
);

// File: tb/tb_uart_bank_regs.sv
`timescale 1ns/1ps
module tb_uart_bank_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = 3'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  lcr_q, ier_q, fcr_q, mcr_q, irpw_q, xfr_q;
    logic [7:0]  xon1_q, xon2_q, xoff1_q, xoff2_q;
    logic [15:0] divisor_q;
    logic        auto_cts_en, auto_rts_en, spec_char_en, enh_en;
    logic [3:0]  swfc_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_bank_regs dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .lcr_q(lcr_q), .ier_q(ier_q),
        .fcr_q(fcr_q), .mcr_q(mcr_q), .divisor_q(divisor_q),
        .irpw_q(irpw_q), .xfr_q(xfr_q), .xon1_q(xon1_q), .xon2_q(xon2_q),
        .xoff1_q(xoff1_q), .xoff2_q(xoff2_q), .auto_cts_en(auto_cts_en),
        .auto_rts_en(auto_rts_en), .spec_char_en(spec_char_en),
        .enh_en(enh_en), .swfc_mode(swfc_mode)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, "read", {8'h00, rdata}, {8'h00, exp});
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "lcr", {8'h0, lcr_q}, 16'h0);
        check("R1", "ier", {8'h0, ier_q}, 16'h0);
        check("R1", "divisor", divisor_q, 16'h0);
        check("R1", "efr bits",
              {11'h0, auto_cts_en, auto_rts_en, spec_char_en, enh_en, 1'b0}, 16'h0);
        rd_check("R1", 3'd3, 8'h00);
    endtask

    task automatic t_normal;
        wr(3'd1, 8'hFF);
        check("R7", "ier locked", {8'h0, ier_q}, 16'h000F);
        wr(3'd2, 8'hFF);
        check("R7", "fcr locked", {8'h0, fcr_q}, 16'h00CF);
        wr(3'd4, 8'hFF);
        check("R7", "mcr locked", {8'h0, mcr_q}, 16'h001F);
        wr(3'd3, 8'h03);
        rd_check("R9", 3'd3, 8'h03);
        rd_check("R2", 3'd1, 8'h0F);
        rd_check("R2", 3'd2, 8'h01);
        rd_check("R2", 3'd4, 8'h1F);
        wr(3'd0, 8'h55);
        wr(3'd5, 8'h66);
        check("R2", "divisor untouched", divisor_q, 16'h0);
        check("R2", "xon2 untouched", {8'h0, xon2_q}, 16'h0);
        rd_check("R2", 3'd0, 8'h00);
        rd_check("R2", 3'd5, 8'h00);
    endtask

    task automatic t_divisor;
        wr(3'd3, 8'h80);
        rd_check("R4", 3'd0, 8'h01);
        rd_check("R4", 3'd1, 8'h04);
        wr(3'd0, 8'h34);
        check("R3", "divisor low", divisor_q, 16'h0034);
        rd_check("R4", 3'd0, 8'h34);
        rd_check("R4", 3'd1, 8'h00);
        wr(3'd1, 8'h12);
        check("R3", "divisor full", divisor_q, 16'h1234);
        check("R3", "ier unchanged", {8'h0, ier_q}, 16'h000F);
        rd_check("R9", 3'd3, 8'h80);
    endtask

    task automatic t_enhanced;
        wr(3'd3, 8'hBF);
        wr(3'd0, 8'hAA);
        check("R7", "irpw locked", {8'h0, irpw_q}, 16'h0);
        wr(3'd2, 8'hD5);
        check("R6", "efr bits",
              {8'h0, auto_cts_en, auto_rts_en, spec_char_en, enh_en, swfc_mode}, 16'h00D5);
        rd_check("R5", 3'd2, 8'hD5);
        wr(3'd4, 8'h11);
        wr(3'd5, 8'h13);
        wr(3'd6, 8'h19);
        wr(3'd7, 8'h93);
        check("R5", "xon1", {8'h0, xon1_q}, 16'h0011);
        check("R5", "xoff2", {8'h0, xoff2_q}, 16'h0093);
        rd_check("R5", 3'd5, 8'h13);
        rd_check("R5", 3'd6, 8'h19);
        wr(3'd0, 8'hAA);
        wr(3'd1, 8'h5B);
        check("R8", "irpw", {8'h0, irpw_q}, 16'h00AA);
        check("R8", "xfr", {8'h0, xfr_q}, 16'h005B);
        check("R5", "divisor kept", divisor_q, 16'h1234);
        check("R5", "mcr kept", {8'h0, mcr_q}, 16'h001F);
        rd_check("R9", 3'd3, 8'hBF);
    endtask

    task automatic t_unlocked;
        wr(3'd3, 8'h03);
        rd_check("R9", 3'd3, 8'h03);
        wr(3'd1, 8'hF3);
        check("R8", "ier", {8'h0, ier_q}, 16'h00F3);
        wr(3'd4, 8'hE0);
        check("R8", "mcr", {8'h0, mcr_q}, 16'h00E0);
        wr(3'd2, 8'h30);
        check("R8", "fcr", {8'h0, fcr_q}, 16'h0030);
    endtask

    task automatic t_timing;
        @(negedge clk);
        addr = 3'd1; rd_en = 1'b0;
        #1;
        check("R10", "idle read", {8'h0, rdata}, 16'h0);
        addr = 3'd1; wdata = 8'h11; wr_en = 1'b1; rd_en = 1'b1;
        #1;
        check("R10", "read before edge", {8'h0, rdata}, 16'h00F3);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10", "read after edge", {8'h0, rdata}, 16'h0011);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal();
        t_divisor();
        t_enhanced();
        t_unlocked();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule